// File: doc/BRIEF.md
# Next-PC and Branch Unit

This block works out, for one instruction per cycle, where the program counter goes next and whether a link value has to be written back to the register file. It takes the current PC, a decoded control-flow kind, a raw immediate field, two source operands with their register indexes, the destination index of the instruction, and the three return-address registers (ra, ea, ba). It drives back the next PC and a link-write request (enable, index, data). For an exception return it also raises a request to copy the saved status into the live status.

The decoder upstream of this block supplies the flow kind and condition codes. Register index 0 is the hard-wired zero register: any operand read through it counts as zero, and a link write aimed at it is dropped. All outputs are registered, so the result for the inputs presented in one cycle appears after the next rising clock edge.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low (asynchronous), `nextPc` equals the `RESET_PC` parameter (default 0), and `linkWe` and `statusRestore` are 0.
- R2: Each output reflects the inputs sampled at the preceding rising edge. Flow kind 0 (sequential), and any kind code from 11 to 15, give `nextPc = pc + 4` with no link write and no status restore.
- R3: Flow kind 1 (absolute jump) gives `nextPc = {pc[31:28], immField[25:0], 2'b00}`. The top four PC bits are kept even when the PC sits at the last word of a 256 MB region.
- R4: Flow kind 2 (absolute call) jumps as in R3 and writes `pc + 4` into register 31.
- R5: Flow kind 3 (unconditional relative branch) gives `nextPc = pc + 4 + sext(immField[15:0])` after the low two bits of the offset have been cleared. `immField[25:16]` is ignored.
- R6: Flow kind 4 (conditional branch) uses the R5 target when the condition holds and `pc + 4` otherwise. Signed codes in `condCode` are: 0 = A >= B, 1 = A < B, 2 = A != B, 3 = A == B.
- R7: Unsigned codes in `condCode` are 4 = A >= B and 5 = A < B. Codes 6 and 7 never take the branch.
- R8: An operand whose index (`srcAIdx` or `srcBIdx`) is 0 reads as zero for both compares and register jumps, whatever value appears on its data input.
- R9: Flow kind 5 (register jump) gives `nextPc` = operand A. Flow kind 6 (register call) does the same and also writes `pc + 4` into register 31.
- R10: Flow kind 7 gives `nextPc = raValue` and flow kind 9 gives `nextPc = baValue`. Neither raises `statusRestore`.
- R11: Flow kind 8 (exception return) gives `nextPc = eaValue` and raises `statusRestore` for that one result cycle.
- R12: Flow kind 10 (next-PC read) gives `nextPc = pc + 4` and writes `pc + 4` into register `destIdx`. When `destIdx` is 0 the write is suppressed (`linkWe` = 0). `linkWe` is never 1 with `linkIdx` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc | input | 32 | PC of the current instruction |
| flowKind | input | 4 | Decoded control-flow kind (codes in R2 to R12) |
| condCode | input | 3 | Branch condition code (R6, R7) |
| immField | input | 26 | Raw immediate. Absolute jumps use all 26 bits, branches use the low 16 |
| srcAIdx | input | 5 | Register index of operand A |
| srcAVal | input | 32 | Register value of operand A |
| srcBIdx | input | 5 | Register index of operand B |
| srcBVal | input | 32 | Register value of operand B |
| destIdx | input | 5 | Destination register index of a next-PC read |
| raValue | input | 32 | Return-address register value |
| eaValue | input | 32 | Exception-return address value |
| baValue | input | 32 | Breakpoint-return address value |
| nextPc | output | 32 | Registered next program counter |
| linkWe | output | 1 | Registered link-write enable |
| linkIdx | output | 5 | Registered link-write register index |
| linkData | output | 32 | Registered link-write data |
| statusRestore | output | 1 | Registered request to copy saved status into status |

## Verification
The assertions compare each registered output with the inputs one cycle earlier. They therefore assume the decoder presents a complete and stable instruction in every cycle, and that the kind and condition codes come from the encodings in the requirements. The stimulus holds all inputs from one falling edge to the next and drives only the listed codes, plus one unused kind code whose fall-back behaviour the bench checks on purpose. The return registers are held at fixed values that are distinct and word-aligned, so each return flavour can be told apart by its result alone.

// File: rtl/npc_pkg.sv
package npc_pkg;

  localparam int KIND_W = 4;
  localparam int COND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    FK_SEQ      = 4'd0,
    FK_JABS     = 4'd1,
    FK_CALLABS  = 4'd2,
    FK_BR       = 4'd3,
    FK_BCOND    = 4'd4,
    FK_JREG     = 4'd5,
    FK_CALLREG  = 4'd6,
    FK_RETRA    = 4'd7,
    FK_RETEA    = 4'd8,
    FK_RETBA    = 4'd9,
    FK_NEXTPC   = 4'd10
  } flow_kind_e;

  typedef enum logic [COND_W-1:0] {
    CC_GE  = 3'd0,
    CC_LT  = 3'd1,
    CC_NE  = 3'd2,
    CC_EQ  = 3'd3,
    CC_GEU = 3'd4,
    CC_LTU = 3'd5
  } cond_e;

  typedef enum logic [2:0] {
    TGT_SEQ,
    TGT_ABS,
    TGT_REL,
    TGT_REG,
    TGT_RA,
    TGT_EA,
    TGT_BA
  } tgt_sel_e;

  typedef struct packed {
    tgt_sel_e tgtSel;
    logic     condBranch;
    logic     linkEn;
    logic     linkToDest;
    logic     restore;
  } npc_strobe_t;

endpackage

// File: rtl/npc_ctrl.sv
module npc_ctrl
  import npc_pkg::*;
(
  input  logic [KIND_W-1:0] flowKind,
  output npc_strobe_t       strobes
);

  always_comb begin
    strobes = '{tgtSel: TGT_SEQ, condBranch: 1'b0, linkEn: 1'b0,
                linkToDest: 1'b0, restore: 1'b0};
    case (flowKind)
      FK_JABS:    strobes.tgtSel = TGT_ABS;
      FK_CALLABS: begin
        strobes.tgtSel = TGT_ABS;
        strobes.linkEn = 1'b1;
      end
      FK_BR:      strobes.tgtSel = TGT_REL;
      FK_BCOND: begin
        strobes.tgtSel     = TGT_REL;
        strobes.condBranch = 1'b1;
      end
      FK_JREG:    strobes.tgtSel = TGT_REG;
      FK_CALLREG: begin
        strobes.tgtSel = TGT_REG;
        strobes.linkEn = 1'b1;
      end
      FK_RETRA:   strobes.tgtSel = TGT_RA;
      FK_RETEA: begin
        strobes.tgtSel  = TGT_EA;
        strobes.restore = 1'b1;
      end
      FK_RETBA:   strobes.tgtSel = TGT_BA;
      FK_NEXTPC: begin
        strobes.linkEn     = 1'b1;
        strobes.linkToDest = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/npc_datapath.sv
module npc_datapath
  import npc_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter int          IDX_W     = 5,
  parameter int          REGION_W  = 4,
  parameter int          BR_IMM_W  = 16,
  parameter int          LINK_REG  = 31,
  parameter logic [31:0] RESET_PC  = 32'h0,
  localparam int         ABS_IMM_W = XLEN - REGION_W - 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  npc_strobe_t          strobes,
  input  logic [COND_W-1:0]    condCode,
  input  logic [XLEN-1:0]      pc,
  input  logic [ABS_IMM_W-1:0] immField,
  input  logic [IDX_W-1:0]     srcAIdx,
  input  logic [XLEN-1:0]      srcAVal,
  input  logic [IDX_W-1:0]     srcBIdx,
  input  logic [XLEN-1:0]      srcBVal,
  input  logic [IDX_W-1:0]     destIdx,
  input  logic [XLEN-1:0]      raValue,
  input  logic [XLEN-1:0]      eaValue,
  input  logic [XLEN-1:0]      baValue,
  output logic [XLEN-1:0]      nextPc,
  output logic                 linkWe,
  output logic [IDX_W-1:0]     linkIdx,
  output logic [XLEN-1:0]      linkData,
  output logic                 statusRestore
);

  localparam int SEXT_W = XLEN - BR_IMM_W;

  logic [XLEN-1:0]  seqPc, absPc, relPc, brOff, opA, opB, target;
  logic             taken;
  logic [IDX_W-1:0] linkIdxD;

  assign seqPc = pc + XLEN'(4);
  assign absPc = {pc[XLEN-1 -: REGION_W], immField, 2'b00};
  assign brOff = {{SEXT_W{immField[BR_IMM_W-1]}}, immField[BR_IMM_W-1:2], 2'b00};
  assign relPc = seqPc + brOff;

  assign opA = (srcAIdx == '0) ? '0 : srcAVal;
  assign opB = (srcBIdx == '0) ? '0 : srcBVal;

  always_comb begin
    case (condCode)
      CC_GE:   taken = $signed(opA) >= $signed(opB);
      CC_LT:   taken = $signed(opA) <  $signed(opB);
      CC_NE:   taken = opA != opB;
      CC_EQ:   taken = opA == opB;
      CC_GEU:  taken = opA >= opB;
      CC_LTU:  taken = opA <  opB;
      default: taken = 1'b0;
    endcase
  end

  always_comb begin
    case (strobes.tgtSel)
      TGT_ABS: target = absPc;
      TGT_REL: target = (strobes.condBranch && !taken) ? seqPc : relPc;
      TGT_REG: target = opA;
      TGT_RA:  target = raValue;
      TGT_EA:  target = eaValue;
      TGT_BA:  target = baValue;
      default: target = seqPc;
    endcase
  end

  assign linkIdxD = strobes.linkToDest ? destIdx : IDX_W'(LINK_REG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nextPc        <= RESET_PC[XLEN-1:0];
      linkWe        <= 1'b0;
      linkIdx       <= '0;
      linkData      <= '0;
      statusRestore <= 1'b0;
    end else begin
      nextPc        <= target;
      linkWe        <= strobes.linkEn && (linkIdxD != '0);
      linkIdx       <= linkIdxD;
      linkData      <= seqPc;
      statusRestore <= strobes.restore;
    end
  end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter int          IDX_W     = 5,
  parameter int          REGION_W  = 4,
  parameter int          BR_IMM_W  = 16,
  parameter int          LINK_REG  = 31,
  parameter logic [31:0] RESET_PC  = 32'h0,
  localparam int         ABS_IMM_W = XLEN - REGION_W - 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [XLEN-1:0]      pc,
  input  logic [KIND_W-1:0]    flowKind,
  input  logic [COND_W-1:0]    condCode,
  input  logic [ABS_IMM_W-1:0] immField,
  input  logic [IDX_W-1:0]     srcAIdx,
  input  logic [XLEN-1:0]      srcAVal,
  input  logic [IDX_W-1:0]     srcBIdx,
  input  logic [XLEN-1:0]      srcBVal,
  input  logic [IDX_W-1:0]     destIdx,
  input  logic [XLEN-1:0]      raValue,
  input  logic [XLEN-1:0]      eaValue,
  input  logic [XLEN-1:0]      baValue,
  output logic [XLEN-1:0]      nextPc,
  output logic                 linkWe,
  output logic [IDX_W-1:0]     linkIdx,
  output logic [XLEN-1:0]      linkData,
  output logic                 statusRestore
);

  npc_strobe_t strobes;

  npc_ctrl u_ctrl (
    .flowKind (flowKind),
    .strobes  (strobes)
  );

  npc_datapath #(
    .XLEN     (XLEN),
    .IDX_W    (IDX_W),
    .REGION_W (REGION_W),
    .BR_IMM_W (BR_IMM_W),
    .LINK_REG (LINK_REG),
    .RESET_PC (RESET_PC)
  ) u_dp (
    .clk           (clk),
    .rst_n         (rst_n),
    .strobes       (strobes),
    .condCode      (condCode),
    .pc            (pc),
    .immField      (immField),
    .srcAIdx       (srcAIdx),
    .srcAVal       (srcAVal),
    .srcBIdx       (srcBIdx),
    .srcBVal       (srcBVal),
    .destIdx       (destIdx),
    .raValue       (raValue),
    .eaValue       (eaValue),
    .baValue       (baValue),
    .nextPc        (nextPc),
    .linkWe        (linkWe),
    .linkIdx       (linkIdx),
    .linkData      (linkData),
    .statusRestore (statusRestore)
  );

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk
  import npc_pkg::*;
#(
  parameter int  XLEN      = 32,
  parameter int  IDX_W     = 5,
  parameter int  REGION_W  = 4,
  parameter int  LINK_REG  = 31,
  localparam int ABS_IMM_W = XLEN - REGION_W - 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [XLEN-1:0]      pc,
  input logic [KIND_W-1:0]    flowKind,
  input logic [XLEN-1:0]      eaValue,
  input logic [XLEN-1:0]      nextPc,
  input logic                 linkWe,
  input logic [IDX_W-1:0]     linkIdx,
  input logic [XLEN-1:0]      linkData,
  input logic                 statusRestore
);

  // R2
  seq_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flowKind == FK_SEQ) |=> (nextPc == $past(pc) + XLEN'(4)) && !linkWe && !statusRestore);

  // R3
  abs_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flowKind == FK_JABS) |=>
      (nextPc[XLEN-1 -: REGION_W] == $past(pc[XLEN-1 -: REGION_W])) && (nextPc[1:0] == 2'b00));

  // R4
  call_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flowKind == FK_CALLABS) |=>
      linkWe && (linkIdx == IDX_W'(LINK_REG)) && (linkData == $past(pc) + XLEN'(4)));

  // R5
  rel_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flowKind == FK_BR) |=> (nextPc[1:0] == $past(pc[1:0])));

  // R11
  restore_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    statusRestore |-> (nextPc == $past(eaValue)));

  // R12
  link_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    linkWe |-> (linkIdx != '0));

endmodule

bind npc_unit npc_unit_chk #(
  .XLEN     (XLEN),
  .IDX_W    (IDX_W),
  .REGION_W (REGION_W),
  .LINK_REG (LINK_REG)
) u_chk (.*);

// File: tb/npc_unit_test.sv
module npc_unit_test;

  typedef struct packed {
    logic [7:0]  req;
    logic [3:0]  kind;
    logic [2:0]  cond;
    logic [25:0] imm;
    logic [31:0] pc;
    logic [4:0]  aIdx;
    logic [31:0] aVal;
    logic [4:0]  bIdx;
    logic [31:0] bVal;
    logic [4:0]  rc;
    logic [31:0] expPc;
    logic        expWe;
    logic [4:0]  expIdx;
    logic [31:0] expData;
    logic        expRst;
  } vec_t;

  localparam int NV = 23;
  localparam logic [31:0] RA_V = 32'h0000_4000;
  localparam logic [31:0] EA_V = 32'h0000_8000;
  localparam logic [31:0] BA_V = 32'h0000_C000;

  localparam vec_t VECS [NV] = '{
    // R2 sequential
    '{8'd2, 4'd0, 3'd0, 26'h0, 32'h0000_1000, 5'd0, 32'h0, 5'd0, 32'h0, 5'd0, 32'h0000_1004, 1'b0, 5'd0, 32'h0, 1'b0},
    // R3 absolute jump
    '{8'd3, 4'd1, 3'd0, 26'h0000040, 32'h1000_0010, 5'd0, 32'h0, 5'd0, 32'h0, 5'd0, 32'h1000_0100, 1'b0, 5'd0, 32'h0, 1'b0},
    // R3 last word of a 256 MB region keeps its region
    '{8'd3, 4'd1, 3'd0, 26'h0, 32'h1FFF_FFFC, 5'd0, 32'h0, 5'd0, 32'h0, 5'd0, 32'h1000_0000, 1'b0, 5'd0, 32'h0, 1'b0},
    // R4 absolute call
    '{8'd4, 4'd2, 3'd0, 26'h0000100, 32'h3000_0020, 5'd0, 32'h0, 5'd0, 32'h0, 5'd0, 32'h3000_0400, 1'b1, 5'd31, 32'h3000_0024, 1'b0},
    // R5 forward branch
    '{8'd5, 4'd3, 3'd0, 26'h0000010, 32'h0000_0100, 5'd0, 32'h0, 5'd0, 32'h0, 5'd0, 32'h0000_0114, 1'b0, 5'd0, 32'h0, 1'b0},
    // R5 backward branch, low bits cleared, upper field ignored
    '{8'd5, 4'd3, 3'd0, 26'h2A5FFF3, 32'h0000_0200, 5'd0, 32'h0, 5'd0, 32'h0, 5'd0, 32'h0000_01F4, 1'b0, 5'd0, 32'h0, 1'b0},
    // R6 signed GE, -1 >= 1 false
    '{8'd6, 4'd4, 3'd0, 26'h0000020, 32'h0000_0300, 5'd1, 32'hFFFF_FFFF, 5'd2, 32'h1, 5'd0, 32'h0000_0304, 1'b0, 5'd0, 32'h0, 1'b0},
    // R7 unsigned GEU, same operands true
    '{8'd7, 4'd4, 3'd4, 26'h0000020, 32'h0000_0300, 5'd1, 32'hFFFF_FFFF, 5'd2, 32'h1, 5'd0, 32'h0000_0324, 1'b0, 5'd0, 32'h0, 1'b0},
    // R6 signed LT true
    '{8'd6, 4'd4, 3'd1, 26'h0000040, 32'h0000_0400, 5'd1, 32'hFFFF_FFFF, 5'd2, 32'h1, 5'd0, 32'h0000_0444, 1'b0, 5'd0, 32'h0, 1'b0},
    // R7 unsigned LTU false
    '{8'd7, 4'd4, 3'd5, 26'h0000040, 32'h0000_0400, 5'd1, 32'hFFFF_FFFF, 5'd2, 32'h1, 5'd0, 32'h0000_0404, 1'b0, 5'd0, 32'h0, 1'b0},
    // R6 NE with equal operands
    '{8'd6, 4'd4, 3'd2, 26'h0000008, 32'h0000_0500, 5'd3, 32'h5, 5'd4, 32'h5, 5'd0, 32'h0000_0504, 1'b0, 5'd0, 32'h0, 1'b0},
    // R6 EQ with equal operands
    '{8'd6, 4'd4, 3'd3, 26'h0000008, 32'h0000_0500, 5'd3, 32'h5, 5'd4, 32'h5, 5'd0, 32'h0000_050C, 1'b0, 5'd0, 32'h0, 1'b0},
    // R8 register 0 compares as zero
    '{8'd8, 4'd4, 3'd3, 26'h0000008, 32'h0000_0600, 5'd0, 32'h77, 5'd3, 32'h0, 5'd0, 32'h0000_060C, 1'b0, 5'd0, 32'h0, 1'b0},
    // R7 code 6 never taken
    '{8'd7, 4'd4, 3'd6, 26'h0000008, 32'h0000_0700, 5'd3, 32'h5, 5'd4, 32'h5, 5'd0, 32'h0000_0704, 1'b0, 5'd0, 32'h0, 1'b0},
    // R9 register jump
    '{8'd9, 4'd5, 3'd0, 26'h0, 32'h0000_0800, 5'd4, 32'h0000_9000, 5'd0, 32'h0, 5'd0, 32'h0000_9000, 1'b0, 5'd0, 32'h0, 1'b0},
    // R8 register jump through register 0
    '{8'd8, 4'd5, 3'd0, 26'h0, 32'h0000_0800, 5'd0, 32'h0000_1234, 5'd0, 32'h0, 5'd0, 32'h0000_0000, 1'b0, 5'd0, 32'h0, 1'b0},
    // R9 register call
    '{8'd9, 4'd6, 3'd0, 26'h0, 32'h0000_0900, 5'd5, 32'h0000_A000, 5'd0, 32'h0, 5'd0, 32'h0000_A000, 1'b1, 5'd31, 32'h0000_0904, 1'b0},
    // R10 return via ra
    '{8'd10, 4'd7, 3'd0, 26'h0, 32'h0000_0100, 5'd0, 32'h0, 5'd0, 32'h0, 5'd0, 32'h0000_4000, 1'b0, 5'd0, 32'h0, 1'b0},
    // R11 exception return
    '{8'd11, 4'd8, 3'd0, 26'h0, 32'h0000_0100, 5'd0, 32'h0, 5'd0, 32'h0, 5'd0, 32'h0000_8000, 1'b0, 5'd0, 32'h0, 1'b1},
    // R10 return via ba
    '{8'd10, 4'd9, 3'd0, 26'h0, 32'h0000_0100, 5'd0, 32'h0, 5'd0, 32'h0, 5'd0, 32'h0000_C000, 1'b0, 5'd0, 32'h0, 1'b0},
    // R12 next-PC read into r7
    '{8'd12, 4'd10, 3'd0, 26'h0, 32'h0000_0A00, 5'd0, 32'h0, 5'd0, 32'h0, 5'd7, 32'h0000_0A04, 1'b1, 5'd7, 32'h0000_0A04, 1'b0},
    // R12 next-PC read into r0 suppressed
    '{8'd12, 4'd10, 3'd0, 26'h0, 32'h0000_0A00, 5'd0, 32'h0, 5'd0, 32'h0, 5'd0, 32'h0000_0A04, 1'b0, 5'd0, 32'h0, 1'b0},
    // R2 unused kind code falls back to sequential
    '{8'd2, 4'd15, 3'd0, 26'h3FFFFFF, 32'h0000_0B00, 5'd0, 32'h0, 5'd0, 32'h0, 5'd0, 32'h0000_0B04, 1'b0, 5'd0, 32'h0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pc = '0;
  logic [3:0]  flowKind = '0;
  logic [2:0]  condCode = '0;
  logic [25:0] immField = '0;
  logic [4:0]  srcAIdx = '0, srcBIdx = '0, destIdx = '0;
  logic [31:0] srcAVal = '0, srcBVal = '0;
  logic [31:0] raValue = RA_V, eaValue = EA_V, baValue = BA_V;
  logic [31:0] nextPc, linkData;
  logic        linkWe, statusRestore;
  logic [4:0]  linkIdx;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  npc_unit uut (
    .clk (clk), .rst_n (rst_n), .pc (pc), .flowKind (flowKind),
    .condCode (condCode), .immField (immField),
    .srcAIdx (srcAIdx), .srcAVal (srcAVal), .srcBIdx (srcBIdx), .srcBVal (srcBVal),
    .destIdx (destIdx), .raValue (raValue), .eaValue (eaValue), .baValue (baValue),
    .nextPc (nextPc), .linkWe (linkWe), .linkIdx (linkIdx), .linkData (linkData),
    .statusRestore (statusRestore)
  );

  task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    // R1 reset state
    #5;
    check(1, "nextPc in reset", nextPc, 32'h0);
    check(1, "linkWe in reset", {31'b0, linkWe}, 32'h0);
    check(1, "statusRestore in reset", {31'b0, statusRestore}, 32'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      pc = VECS[i].pc; flowKind = VECS[i].kind; condCode = VECS[i].cond;
      immField = VECS[i].imm; srcAIdx = VECS[i].aIdx; srcAVal = VECS[i].aVal;
      srcBIdx = VECS[i].bIdx; srcBVal = VECS[i].bVal; destIdx = VECS[i].rc;
      @(posedge clk);
      @(negedge clk);
      check(int'(VECS[i].req), $sformatf("vec %0d nextPc", i), nextPc, VECS[i].expPc);
      check(int'(VECS[i].req), $sformatf("vec %0d linkWe", i), {31'b0, linkWe}, {31'b0, VECS[i].expWe});
      if (VECS[i].expWe) begin
        check(int'(VECS[i].req), $sformatf("vec %0d linkIdx", i), {27'b0, linkIdx}, {27'b0, VECS[i].expIdx});
        check(int'(VECS[i].req), $sformatf("vec %0d linkData", i), linkData, VECS[i].expData);
      end
      check(int'(VECS[i].req), $sformatf("vec %0d statusRestore", i),
            {31'b0, statusRestore}, {31'b0, VECS[i].expRst});
    end

    // R11 restore lasts one result cycle only
    flowKind = 4'd8; pc = 32'h0000_0C00;
    @(posedge clk); @(negedge clk);
    flowKind = 4'd0;
    @(posedge clk); @(negedge clk);
    check(11, "restore drops after one cycle", {31'b0, statusRestore}, 32'h0);
    check(2, "sequential after eret", nextPc, 32'h0000_0C04);

    // R1 asynchronous reset mid-run after a call
    flowKind = 4'd2; pc = 32'h5000_0000; immField = 26'h10;
    @(posedge clk); @(negedge clk);
    check(4, "call before reset", {31'b0, linkWe}, 32'h1);
    rst_n = 1'b0;
    #2;
    check(1, "nextPc after async reset", nextPc, 32'h0);
    check(1, "linkWe after async reset", {31'b0, linkWe}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    flowKind = 4'd0;
    @(posedge clk); @(negedge clk);

    finishRun();
  end

endmodule